// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block sits between an 8-bit controller core and a multiplexed external memory bus. Clocked at the oscillator rate, it divides time into machine cycles of twelve oscillator periods. In each period it drives the address latch strobe (`ale`), the code read strobe (`psen_n`), the data read and write strobes (`rd_n`, `wr_n`), the shared low address/data byte (`ad_out` with its drive enable `ad_oe`) and the high address byte (`a_hi`).

The core makes one request per machine cycle: a code fetch, a data read or a data write. The request is accepted only on the last period of a cycle, which the block flags with `cyc_end`. A code fetch spends the next machine cycle in two fetch slots of six periods each and returns the bytes at the requested address and at the following address. A data access gives up the second latch pulse and both code-read pulses of its cycle, so that a single six-period read or write strobe can use that time. When no request is pending, the block runs an idle cycle: the same strobes as a fetch, at the last fetch address, with no bytes returned. After reset the block stays quiet until the first cycle boundary.

The FSM has five states. HALT is the reset state and drives no strobe. IDLE, FETCH, READ and WRITE each last one machine cycle. Every state moves on at the boundary edge. The next state is FETCH, READ or WRITE for a pending request of kind 0, 1 or 2, and IDLE when no request is pending or when the kind is 3.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, and `ad_oe`, `busy` and `rsp_valid` are 0. `cyc_end` is 1, so the first edge after reset is a cycle boundary.
- R2: Periods are numbered 0 to 11 within a machine cycle, and `cyc_end` is high in period 11. A request (`req_valid`, with kind 0 fetch, 1 read, 2 write) is taken only on the edge that ends period 11. `busy` is 0 until that edge and then stays high for all twelve periods of the access cycle.
- R3: In fetch and idle cycles, `ale` is high in periods 0, 1, 6 and 7 and low in all other periods.
- R4: In fetch and idle cycles, `psen_n` is low in periods 3 to 5 and 9 to 11, a three-period pulse that starts one period after `ale` falls.
- R5: In every cycle, the low address is driven on `ad_out` with `ad_oe` high from the start of the latch pulse until one period after `ale` falls. During fetch and read cycles, `ad_oe` is low for the rest of each slot.
- R6: In read and write cycles, `ale` is high only in periods 0 and 1, and `psen_n` stays high for the whole cycle.
- R7: In a read cycle, `rd_n` is low in periods 5 to 10. The byte on `ad_in` at the edge that ends period 10 appears on `rsp_data` with `rsp_valid` high during period 11.
- R8: In a write cycle, `wr_n` is low in periods 5 to 10. `ad_out` carries the write byte with `ad_oe` high from period 3 through period 11, one period past the rising edge of `wr_n`.
- R9: `a_hi` carries the high byte of the current fetch address in each fetch slot. For a data access it carries the high byte of `req_addr` when `req_wide` is 1, and the value of `port_hi` sampled at acceptance when `req_wide` is 0.
- R10: A fetch of address A captures `ad_in` at the edges that end periods 5 and 11. It returns the byte at A with `rsp_valid` high in period 6 and the byte at A+1 in period 0 of the next cycle.
- R11: An idle cycle repeats the fetch strobes at the address of the last accepted fetch (0 after reset), keeps `busy` at 0 and returns no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is pending |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write |
| req_wide | input | 1 | Data access uses a 16-bit address |
| req_addr | input | 16 | Fetch or data address |
| req_wdata | input | 8 | Byte to write |
| port_hi | input | 8 | High byte used by 8-bit data accesses |
| cyc_end | output | 1 | Last period of the machine cycle |
| busy | output | 1 | An accepted access is running |
| rsp_valid | output | 1 | `rsp_data` holds a captured byte |
| rsp_data | output | 8 | Fetched or read byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low address or write data |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 8 | Byte returned by external memory |
| a_hi | output | 8 | High address byte |

## Verification
The bench checks every period of each cycle kind against its own timing table: fetches with and without a high-byte carry into A+1, wide and narrow reads, wide and narrow writes, and idle cycles placed before and after data accesses. Fetches placed right after writes show that the skipped pulses come back at once. A model memory returns a byte that depends on the latched address. A wrong high byte, a capture on the wrong edge, or a fetch of A+1 that drops the carry therefore each give a different response. One request is raised in the middle of an idle cycle and held, which shows that acceptance waits for the boundary.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        CYC_HALT,
        CYC_IDLE,
        CYC_FETCH,
        CYC_READ,
        CYC_WRITE
    } cyc_e;

    localparam int PH_W = 4;
    localparam logic [PH_W-1:0] P_LAST      = 4'd11;
    localparam logic [PH_W-1:0] P_SLOT      = 4'd6;
    localparam logic [PH_W-1:0] P_ALE_LEN   = 4'd2;
    localparam logic [PH_W-1:0] P_ADDR_END  = 4'd2;
    localparam logic [PH_W-1:0] P_PSEN_BEG  = 4'd3;
    localparam logic [PH_W-1:0] P_SLOT_LAST = 4'd5;
    localparam logic [PH_W-1:0] P_STB_BEG   = 4'd5;
    localparam logic [PH_W-1:0] P_STB_END   = 4'd10;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_READ  = 2'd1;
    localparam logic [1:0] KIND_WRITE = 2'd2;
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
    import xbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= P_LAST;
        else if (phase == P_LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign last = (phase == P_LAST);
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W = ADDR_W - DATA_W
) (
    input  cyc_e              state,
    input  logic [PH_W-1:0]   phase,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wide,
    input  logic [HI_W-1:0]   port_hi,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic [HI_W-1:0]   a_hi,
    output logic              cap_en
);
    logic              slot1;
    logic [PH_W-1:0]   sub;
    logic [ADDR_W-1:0] slot_addr;
    logic [HI_W-1:0]   data_hi;

    always_comb begin
        slot1     = (phase >= P_SLOT);
        sub       = slot1 ? (phase - P_SLOT) : phase;
        slot_addr = slot1 ? (fetch_addr + ADDR_W'(1)) : fetch_addr;
        data_hi   = wide ? data_addr[ADDR_W-1:DATA_W] : port_hi;
    end

    always_comb begin
        ale    = 1'b0;
        psen_n = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad_oe  = 1'b0;
        ad_out = '0;
        a_hi   = '0;
        cap_en = 1'b0;
        unique case (state)
            CYC_HALT: ;
            CYC_IDLE, CYC_FETCH: begin
                ale    = (sub < P_ALE_LEN);
                psen_n = !(sub >= P_PSEN_BEG);
                ad_oe  = (sub <= P_ADDR_END);
                ad_out = slot_addr[DATA_W-1:0];
                a_hi   = slot_addr[ADDR_W-1:DATA_W];
                cap_en = (state == CYC_FETCH) && (sub == P_SLOT_LAST);
            end
            CYC_READ: begin
                ale    = (phase < P_ALE_LEN);
                rd_n   = !(phase >= P_STB_BEG && phase <= P_STB_END);
                ad_oe  = (phase <= P_ADDR_END);
                ad_out = data_addr[DATA_W-1:0];
                a_hi   = data_hi;
                cap_en = (phase == P_STB_END);
            end
            CYC_WRITE: begin
                ale    = (phase < P_ALE_LEN);
                wr_n   = !(phase >= P_STB_BEG && phase <= P_STB_END);
                ad_oe  = 1'b1;
                ad_out = (phase <= P_ADDR_END) ? data_addr[DATA_W-1:0] : wdata;
                a_hi   = data_hi;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en)
                rsp_data <= ad_in;
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [HI_W-1:0]   port_hi,
    output logic              cyc_end,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   a_hi
);
    logic [PH_W-1:0]   phase;
    cyc_e              state_q, state_d;
    logic [ADDR_W-1:0] fetch_addr_q, data_addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wide_q;
    logic [HI_W-1:0]   port_hi_q;
    logic              cap_en;

    xbus_phase_ctr u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .last  (cyc_end)
    );

    always_comb begin
        state_d = state_q;
        if (cyc_end) begin
            if (!req_valid)
                state_d = CYC_IDLE;
            else begin
                unique case (req_kind)
                    KIND_FETCH: state_d = CYC_FETCH;
                    KIND_READ:  state_d = CYC_READ;
                    KIND_WRITE: state_d = CYC_WRITE;
                    default:    state_d = CYC_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= CYC_HALT;
            fetch_addr_q <= '0;
            data_addr_q  <= '0;
            wdata_q      <= '0;
            wide_q       <= 1'b0;
            port_hi_q    <= '0;
        end else begin
            state_q <= state_d;
            if (cyc_end && req_valid) begin
                if (req_kind == KIND_FETCH)
                    fetch_addr_q <= req_addr;
                data_addr_q <= req_addr;
                wdata_q     <= req_wdata;
                wide_q      <= req_wide;
                port_hi_q   <= port_hi;
            end
        end
    end

    assign busy = (state_q == CYC_FETCH) || (state_q == CYC_READ) || (state_q == CYC_WRITE);

    xbus_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .state      (state_q),
        .phase      (phase),
        .fetch_addr (fetch_addr_q),
        .data_addr  (data_addr_q),
        .wdata      (wdata_q),
        .wide       (wide_q),
        .port_hi    (port_hi_q),
        .ale        (ale),
        .psen_n     (psen_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .ad_oe      (ad_oe),
        .ad_out     (ad_out),
        .a_hi       (a_hi),
        .cap_en     (cap_en)
    );

    xbus_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .ad_in     (ad_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> ($past(phase) == P_LAST)); // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cyc_end) |=> busy); // R2
    AST_NO_PSEN_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CYC_READ || state_q == CYC_WRITE) |-> psen_n); // R6
    AST_BUS_FREE_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R5
    AST_WR_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && $stable(ad_out))); // R8
    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(phase) == P_SLOT_LAST || $past(phase) == P_STB_END
                       || $past(phase) == P_LAST)); // R10
endmodule

// File: tb/xbus_seq_bench.sv
module xbus_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  port_hi = '0;
    logic        cyc_end, busy, rsp_valid, ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0]  rsp_data, ad_out, ad_in, a_hi;
    logic [15:0] lat_q = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] last_fetch = '0;

    // vector: [25:24] kind, [23] busy, [22] ale, [21] psen_n, [20] rd_n,
    // [19] wr_n, [18] oe, [17:10] ad_out, [9:2] a_hi, [1] rsp_chk, [0] rsp_exp
    logic [25:0] vq[$];
    logic [7:0]  rq[$];

    always #2 clk = ~clk;

    xbus_seq u_xbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .port_hi(port_hi), .cyc_end(cyc_end), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
    );

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    // external memory model: address latched while ale is high
    always @(negedge clk) if (ale) lat_q <= {a_hi, ad_out};
    assign ad_in = mem(lat_q);

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
        end
    endtask

    // kind: 0 fetch, 1 read, 2 write, 3 idle
    function automatic logic [25:0] exp_vec(input int kind, input int p, input logic [15:0] addr,
                                            input logic [7:0] wd, input logic [7:0] hi);
        logic [15:0] sa;
        int s;
        logic b, al, ps, rd, wr, oe, rx;
        logic [7:0] ao, ah;
        s = p % 6;
        sa = (p >= 6) ? addr + 16'd1 : addr;
        b = (kind != 3); al = 0; ps = 1; rd = 1; wr = 1; oe = 0; ao = 0; ah = 0; rx = 0;
        if (kind == 0 || kind == 3) begin
            al = (s < 2); ps = !(s >= 3); oe = (s <= 2); ao = sa[7:0]; ah = sa[15:8];
            rx = (kind == 0) && (p == 6);
        end else begin
            al = (p < 2); oe = (kind == 2) || (p <= 2); ah = hi;
            ao = (p <= 2) ? addr[7:0] : wd;
            if (kind == 1) begin rd = !(p >= 5 && p <= 10); rx = (p == 11); end
            else wr = !(p >= 5 && p <= 10);
        end
        return {2'(kind), b, al, ps, rd, wr, oe, ao, ah, (p != 0), rx};
    endfunction

    task automatic issue(input int kind, input logic wide, input logic [15:0] addr,
                         input logic [7:0] wd, input logic [7:0] phi);
        logic [7:0] hi;
        logic [15:0] ea;
        while (!cyc_end) @(negedge clk);
        req_valid = (kind != 3);
        req_kind  = 2'(kind);
        req_wide  = wide;
        req_addr  = addr;
        req_wdata = wd;
        port_hi   = phi;
        if (kind == 0) last_fetch = addr;
        ea = (kind == 3) ? last_fetch : addr;
        hi = wide ? addr[15:8] : phi;
        for (int p = 0; p < 12; p++) vq.push_back(exp_vec(kind, p, ea, wd, hi));
        if (kind == 0) begin rq.push_back(mem(addr)); rq.push_back(mem(addr + 16'd1)); end
        if (kind == 1) rq.push_back(mem({hi, addr[7:0]}));
        @(negedge clk);
        req_valid = 1'b0;
        port_hi = 8'hEE;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rsp_valid) begin
                if (rq.size() == 0) check("R11 unexpected rsp_valid", 16'(rsp_valid), 16'd0);
                else begin
                    logic [7:0] e;
                    e = rq.pop_front();
                    check("R7/R10 rsp_data", 16'(rsp_data), 16'(e));
                end
            end
            if (vq.size() != 0) begin
                logic [25:0] v;
                v = vq.pop_front();
                check("R2/R11 busy", 16'(busy), 16'(v[23]));
                check("R3/R6 ale", 16'(ale), 16'(v[22]));
                check("R4/R6 psen_n", 16'(psen_n), 16'(v[21]));
                check("R7 rd_n", 16'(rd_n), 16'(v[20]));
                check("R8 wr_n", 16'(wr_n), 16'(v[19]));
                check("R5/R8 ad_oe", 16'(ad_oe), 16'(v[18]));
                if (v[18]) check("R5/R8 ad_out", 16'(ad_out), 16'(v[17:10]));
                check("R9 a_hi", 16'(a_hi), 16'(v[9:2]));
                if (v[1]) check("R10/R7/R11 rsp_valid", 16'(rsp_valid), 16'(v[0]));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ale", 16'(ale), 16'd0);
        check("R1 psen_n", 16'(psen_n), 16'd1);
        check("R1 rd_n", 16'(rd_n), 16'd1);
        check("R1 wr_n", 16'(wr_n), 16'd1);
        check("R1 ad_oe", 16'(ad_oe), 16'd0);
        check("R1 busy", 16'(busy), 16'd0);
        check("R1 rsp_valid", 16'(rsp_valid), 16'd0);
        check("R1 cyc_end", 16'(cyc_end), 16'd1);
        rst_n = 1'b1;
        // R11: idle cycles before any fetch use address 0
        issue(3, 0, 16'h0, 8'h0, 8'h0);
        issue(3, 0, 16'h0, 8'h0, 8'h0);
        // R2: request raised mid-cycle is held until the boundary
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_wide = 1'b1; req_addr = 16'h4411;
        while (!cyc_end) begin
            check("R2 busy before boundary", 16'(busy), 16'd0);
            @(negedge clk);
        end
        issue(1, 1, 16'h4411, 8'h0, 8'h0);
        // R9/R10: fetch with carry into the high byte
        issue(0, 0, 16'h12FF, 8'h0, 8'h0);
        issue(0, 0, 16'h0040, 8'h0, 8'h0);
        // R7/R9: wide and narrow reads
        issue(1, 1, 16'hA55A, 8'h0, 8'h77);
        issue(1, 0, 16'h9933, 8'h0, 8'hC4);
        // R8: wide and narrow writes, then fetch right after
        issue(2, 1, 16'h1234, 8'h9E, 8'h00);
        issue(2, 0, 16'hFF81, 8'h3C, 8'h5D);
        issue(0, 0, 16'h7FFE, 8'h0, 8'h0);
        issue(2, 1, 16'h0001, 8'hA5, 8'h00);
        // R11: idle at last fetch address
        issue(3, 0, 16'h0, 8'h0, 8'h0);
        issue(3, 0, 16'h0, 8'h0, 8'h0);
        repeat (14) @(negedge clk);
        check("R10/R7 responses drained", 16'(rq.size()), 16'd0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule